// File: doc/BRIEF.md
# Bus Ownership and Atomic Lock Controller

This block connects a processor core to a bus shared by several masters. When the core wants a transfer, the block pulls its active-low request line low toward an external arbiter. It waits for the arbiter's active-low grant. It starts a bus cycle on the next clock only when the shared busy line is idle and no other master holds the shared lock line. While it owns a cycle, it drives the open-drain style busy and lock lines low. It also enables its status lines and strobes. At every other time those outputs are three-stated.

The core marks atomic read-modify-write sequences with a hold input. When a cycle ends with that input high, the block keeps the lock line asserted through the gap before its next cycle, so no other master can claim the bus in between. When the cycle ends with the input low, the lock is released, and in ordinary cycles lock simply mirrors busy. The block watches the busy line at all times, including cycles run by other masters. It emits a one-clock strobe whenever the synchronized busy line returns high, which tells a fault register to capture its inputs.

Top module: `bus_own_lock`

## Requirements
- R1: `bus_req_n_o` is 0 exactly while `xfer_req_i` is 1 and no own cycle is in progress; it is 1 during an own cycle and while no transfer is wanted.
- R2: A cycle starts on the clock edge at which `xfer_req_i` is 1, `bus_gnt_n_i` is 0, the synchronized busy line is 1, and either the synchronized lock line is 1 or this block holds the lock. `busy_drv_o` rises after that edge.
- R3: `bus_oe_o` is 1 only while an own cycle is in progress and `bus_gnt_n_i` is 0; otherwise the status lines and strobes are three-stated.
- R4: `busy_drv_o` (1 = drive busy low) stays 1 for exactly CYC_CLKS clocks per cycle and is 0 (line released) otherwise.
- R5: When no atomic sequence is held, `lock_drv_o` equals `busy_drv_o`.
- R6: A cycle that ends with `lock_seq_i` at 1 leaves `lock_drv_o` at 1 until the end of the next own cycle that ends with `lock_seq_i` at 0. A lock held by another master (line 0, not driven here) blocks a new start.
- R7: `fault_smp_o` is a single-clock pulse each time the synchronized busy line changes from 0 to 1, whether the cycle was this block's or another master's.
- R8: `xfer_done_o` is 1 in the last clock of each own cycle only.
- R9: While `rst_n` is 0, request is 1, all drives and enables are 0, the lock is released, and no strobe is produced.
- R10: The busy and lock lines are seen through SYNC_STAGES flops. A change on the line has its effect on start and strobe only after that many clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xfer_req_i | input | 1 | Core wants a bus cycle |
| lock_seq_i | input | 1 | Core: more cycles of an atomic sequence follow |
| bus_gnt_n_i | input | 1 | Arbiter grant, active low |
| bus_busy_n_i | input | 1 | Sampled level of the shared busy line |
| bus_lock_n_i | input | 1 | Sampled level of the shared lock line |
| bus_req_n_o | output | 1 | Bus request to arbiter, active low |
| busy_drv_o | output | 1 | 1 = drive busy line low |
| lock_drv_o | output | 1 | 1 = drive lock line low |
| bus_oe_o | output | 1 | Enable for status lines and strobes |
| xfer_done_o | output | 1 | Last clock of an own cycle |
| fault_smp_o | output | 1 | Fault register sample strobe |

## Verification
The block is driven by a plain single transfer, by a transfer held off by a high grant, and by transfers blocked by another master's busy or lock. These patterns show that each of the start conditions in R2 is checked on its own. A three-cycle atomic sequence shows whether the lock is held through the idle gaps and whether it is released only after the final cycle, which separates the R5 behaviour from the R6 behaviour. Foreign busy pulses with the request idle show that the fault strobe depends on the line and not on ownership. Back-to-back own cycles show the strobe firing on this block's own release.

// File: rtl/bus_own_lock_pkg.sv
package bus_own_lock_pkg;
   localparam int unsigned MIN_SYNC = 2;

   function automatic int unsigned cnt_width(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/bus_line_sync.sv
module bus_line_sync #(
   parameter int unsigned WIDTH  = 2,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] line_i,
   output logic [WIDTH-1:0] line_o
);
   import bus_own_lock_pkg::*;

   if (STAGES < MIN_SYNC) begin : g_bad_stages
      $error("bus_line_sync: STAGES below minimum");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stage_q[s] <= '1;
         end else if (s == 0) begin
            stage_q[s] <= line_i;
         end else begin
            stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
         end
      end
   end

   assign line_o = stage_q[STAGES-1];
endmodule

// File: rtl/bus_cycle_ctrl.sv
module bus_cycle_ctrl #(
   parameter int unsigned CYC_CLKS = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic xfer_req_i,
   input  logic lock_seq_i,
   input  logic gnt_n_i,
   input  logic busy_idle_i,
   input  logic lock_idle_i,
   output logic in_cycle_o,
   output logic last_o,
   output logic hold_o
);
   import bus_own_lock_pkg::*;

   localparam int unsigned CW = cnt_width(CYC_CLKS);
   localparam logic [CW-1:0] LOAD = CW'(CYC_CLKS - 1);

   if (CYC_CLKS < 1) begin : g_bad_len
      $error("bus_cycle_ctrl: CYC_CLKS must be at least 1");
   end

   logic          in_cycle_q;
   logic [CW-1:0] cnt_q;
   logic          hold_q;
   logic          start;
   logic          last;

   assign start = xfer_req_i && !in_cycle_q && !gnt_n_i && busy_idle_i
                  && (lock_idle_i || hold_q);
   assign last  = in_cycle_q && (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_cycle_q <= 1'b0;
         cnt_q      <= '0;
         hold_q     <= 1'b0;
      end else if (start) begin
         in_cycle_q <= 1'b1;
         cnt_q      <= LOAD;
      end else if (last) begin
         in_cycle_q <= 1'b0;
         hold_q     <= lock_seq_i;
      end else if (in_cycle_q) begin
         cnt_q      <= cnt_q - 1'b1;
      end
   end

   assign in_cycle_o = in_cycle_q;
   assign last_o     = last;
   assign hold_o     = hold_q;
endmodule

// File: rtl/bus_rise_strobe.sv
module bus_rise_strobe (
   input  logic clk,
   input  logic rst_n,
   input  logic level_i,
   output logic pulse_o
);
   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= level_i;
   end

   assign pulse_o = level_i && !prev_q;
endmodule

// File: rtl/bus_own_lock.sv
module bus_own_lock #(
   parameter int unsigned CYC_CLKS    = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic xfer_req_i,
   input  logic lock_seq_i,
   input  logic bus_gnt_n_i,
   input  logic bus_busy_n_i,
   input  logic bus_lock_n_i,
   output logic bus_req_n_o,
   output logic busy_drv_o,
   output logic lock_drv_o,
   output logic bus_oe_o,
   output logic xfer_done_o,
   output logic fault_smp_o
);
   localparam int unsigned NLINES = 2;

   logic [NLINES-1:0] line_raw;
   logic [NLINES-1:0] line_syn;
   logic              in_cycle;
   logic              last;
   logic              hold;

   assign line_raw = {bus_lock_n_i, bus_busy_n_i};

   bus_line_sync #(.WIDTH(NLINES), .STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .line_i (line_raw),
      .line_o (line_syn)
   );

   bus_cycle_ctrl #(.CYC_CLKS(CYC_CLKS)) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .xfer_req_i  (xfer_req_i),
      .lock_seq_i  (lock_seq_i),
      .gnt_n_i     (bus_gnt_n_i),
      .busy_idle_i (line_syn[0]),
      .lock_idle_i (line_syn[1]),
      .in_cycle_o  (in_cycle),
      .last_o      (last),
      .hold_o      (hold)
   );

   bus_rise_strobe u_strobe (
      .clk     (clk),
      .rst_n   (rst_n),
      .level_i (line_syn[0]),
      .pulse_o (fault_smp_o)
   );

   assign bus_req_n_o = !(xfer_req_i && !in_cycle);
   assign busy_drv_o  = in_cycle;
   assign lock_drv_o  = in_cycle || hold;
   assign bus_oe_o    = in_cycle && !bus_gnt_n_i;
   assign xfer_done_o = last;
endmodule

// File: rtl/bus_own_lock_chk.sv
module bus_own_lock_chk (
   input logic clk,
   input logic rst_n,
   input logic xfer_req_i,
   input logic bus_gnt_n_i,
   input logic bus_req_n_o,
   input logic busy_drv_o,
   input logic lock_drv_o,
   input logic bus_oe_o,
   input logic xfer_done_o,
   input logic fault_smp_o
);
   p_req_off_in_cycle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      busy_drv_o |-> bus_req_n_o);

   p_start_needs_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_drv_o) |-> $past(!bus_gnt_n_i && xfer_req_i));

   p_oe_owned_r3: assert property (@(posedge clk) disable iff (!rst_n)
      bus_oe_o |-> (busy_drv_o && !bus_gnt_n_i));

   p_lock_covers_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
      busy_drv_o |-> lock_drv_o);

   p_strobe_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      fault_smp_o |=> !fault_smp_o);

   p_done_in_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_done_o |-> busy_drv_o);

   p_done_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_done_o |=> !busy_drv_o);
endmodule

bind bus_own_lock bus_own_lock_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .xfer_req_i  (xfer_req_i),
   .bus_gnt_n_i (bus_gnt_n_i),
   .bus_req_n_o (bus_req_n_o),
   .busy_drv_o  (busy_drv_o),
   .lock_drv_o  (lock_drv_o),
   .bus_oe_o    (bus_oe_o),
   .xfer_done_o (xfer_done_o),
   .fault_smp_o (fault_smp_o)
);

// File: tb/bus_own_lock_bench.sv
`timescale 1ns/1ps
module bus_own_lock_bench;
   localparam int CYC  = 4;
   localparam int SYNC = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic xfer_req = 1'b0;
   logic lock_seq = 1'b0;
   logic gnt_n = 1'b1;
   logic f_busy = 1'b0;
   logic f_lock = 1'b0;

   logic req_n, busy_drv, lock_drv, oe, done, fsmp;
   logic busy_line, lock_line;

   assign busy_line = !(busy_drv || f_busy);
   assign lock_line = !(lock_drv || f_lock);

   always #4 clk = !clk;

   bus_own_lock #(.CYC_CLKS(CYC), .SYNC_STAGES(SYNC)) u_bus_own_lock (
      .clk (clk), .rst_n (rst_n),
      .xfer_req_i (xfer_req), .lock_seq_i (lock_seq),
      .bus_gnt_n_i (gnt_n), .bus_busy_n_i (busy_line), .bus_lock_n_i (lock_line),
      .bus_req_n_o (req_n), .busy_drv_o (busy_drv), .lock_drv_o (lock_drv),
      .bus_oe_o (oe), .xfer_done_o (done), .fault_smp_o (fsmp)
   );

   int checks = 0;
   int fails  = 0;

   // Behavioural reference
   bit m_inc = 0;
   int m_left = 0;
   bit m_hold = 0;
   bit m_prev = 1;
   bit qb[$];
   bit ql[$];

   initial begin
      for (int i = 0; i < SYNC; i++) begin qb.push_back(1'b1); ql.push_back(1'b1); end
   end

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_inc = 0; m_left = 0; m_hold = 0; m_prev = 1;
         for (int i = 0; i < SYNC; i++) begin qb[i] = 1'b1; ql[i] = 1'b1; end
      end else begin
         bit bs, ls, mline_b, mline_l, go;
         bs = qb[SYNC-1];
         ls = ql[SYNC-1];
         mline_b = !(m_inc || f_busy);
         mline_l = !(m_inc || m_hold || f_lock);
         go = xfer_req && !m_inc && !gnt_n && bs && (ls || m_hold);
         if (go) begin
            m_inc = 1; m_left = CYC;
         end else if (m_inc) begin
            m_left = m_left - 1;
            if (m_left == 0) begin m_inc = 0; m_hold = lock_seq; end
         end
         qb.push_front(mline_b); void'(qb.pop_back());
         ql.push_front(mline_l); void'(ql.pop_back());
         m_prev = bs;
      end
   end

   task automatic chk(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         chk("R1 bus_req_n_o", req_n, !(xfer_req && !m_inc));
         chk("R2/R4 busy_drv_o", busy_drv, m_inc);
         chk("R5/R6 lock_drv_o", lock_drv, m_inc || m_hold);
         chk("R3 bus_oe_o", oe, m_inc && !gnt_n);
         chk("R8 xfer_done_o", done, m_inc && m_left == 1);
         chk("R7/R10 fault_smp_o", fsmp, qb[SYNC-1] && !m_prev);
      end
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic one_xfer(input bit lk);
      int t;
      lock_seq = lk;
      xfer_req = 1'b1;
      t = 0;
      while (!done && t < 100) begin @(negedge clk); t++; end
      xfer_req = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      idle(2);
      // R9: reset state
      chk("R9 req_n reset", req_n, 1'b1);
      chk("R9 busy reset", busy_drv, 1'b0);
      chk("R9 lock reset", lock_drv, 1'b0);
      chk("R9 oe reset", oe, 1'b0);
      chk("R9 strobe reset", fsmp, 1'b0);
      rst_n = 1'b1;
      idle(3);
      // R1/R2: request with grant withheld
      xfer_req = 1'b1;
      idle(6);
      chk("R2 no start without grant", busy_drv, 1'b0);
      // R2: grant given, plain cycle
      gnt_n = 1'b0;
      idle(1);
      while (!done) @(negedge clk);
      xfer_req = 1'b0;
      idle(6);
      // R2/R10: foreign busy blocks start
      f_busy = 1'b1;
      idle(1);
      xfer_req = 1'b1;
      idle(8);
      chk("R2 foreign busy blocks", busy_drv, 1'b0);
      f_busy = 1'b0;
      while (!done) @(negedge clk);
      xfer_req = 1'b0;
      idle(6);
      // R6: foreign lock blocks start
      f_lock = 1'b1;
      idle(2);
      xfer_req = 1'b1;
      idle(8);
      chk("R6 foreign lock blocks", busy_drv, 1'b0);
      f_lock = 1'b0;
      while (!done) @(negedge clk);
      xfer_req = 1'b0;
      idle(6);
      // R6: atomic sequence of three cycles
      one_xfer(1'b1);
      idle(3);
      chk("R6 lock held in gap", lock_drv, 1'b1);
      one_xfer(1'b1);
      idle(2);
      one_xfer(1'b0);
      idle(2);
      chk("R6 lock released", lock_drv, 1'b0);
      // R3: grant removed in mid cycle
      xfer_req = 1'b1;
      idle(4);
      gnt_n = 1'b1;
      idle(1);
      chk("R3 oe off without grant", oe, 1'b0);
      gnt_n = 1'b0;
      while (!done) @(negedge clk);
      xfer_req = 1'b0;
      idle(6);
      // R7: foreign busy pulses with no request
      for (int k = 1; k <= 3; k++) begin
         f_busy = 1'b1; idle(k + 2);
         f_busy = 1'b0; idle(5);
      end
      // R1/R7: back-to-back own cycles
      xfer_req = 1'b1;
      idle(30);
      xfer_req = 1'b0;
      idle(8);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule